// File: doc/BRIEF.md
# DSI Video-Mode Line and Frame Timer

This block produces the horizontal and vertical timing of a display serial link in video mode. All horizontal durations are counted in lane-byte clock cycles, not pixel clocks. Vertical durations are counted in whole lines. On every cycle the block reports where the link is in the frame. A packet layer downstream uses these outputs to decide when to send sync packets, when to send pixel data, when to send blanking, and when it may drop the lanes to low power.

Software first writes the horizontal and vertical durations, the transmission style and a low-power mask through a small write-only register port. It then sets the run bit. Every timing value is held in a shadow bank that is copied only at a frame boundary. A reprogrammed mode therefore never tears a frame that is already being sent. Three transmission styles are supported: non-burst with sync pulses, non-burst with sync events, and burst. In burst style the active pixel window is shortened by a fixed compression factor.

Top module: `dsi_video_timer`

## Requirements
- R1: After reset, and whenever the run bit is 0, every output is 0. Configuration writes made while run is 0 start nothing.
- R2: While the command-mode bit is 1, no timing is produced and every output stays 0, even if run is 1.
- R3: A line is laid out in this order: sync-active (hsync cycles), back porch (hback cycles), active window, front porch. `sync_start` is high on the first cycle of every line. `eol` is high on the last cycle. The line length equals the programmed line total.
- R4: The front porch is the line total minus sync, back porch and active window, floored at zero. When the total is smaller than that sum, the line length is the sum instead, with a minimum of one cycle.
- R5: The lines of a frame run in this order: vsync, vback, vactive, vfront. `act` is high only in the active window of an active line. `blank` is its complement while running. `vsync_line` marks vsync lines. `eof` is high on the last cycle of the last line. When all four line counts are 0, a frame is a single front-porch line.
- R6: Style 0 (sync pulses) raises `sync_end` on the first cycle after the sync-active part of each line.
- R7: Style 1 (sync events) never raises `sync_end`.
- R8: Styles 2 and 3 (burst) shorten the active window to ceil(pixels / 2^BURST_SHIFT) cycles and never raise `sync_end`. In styles 0 and 1 the active window is one cycle per pixel.
- R9: `lp_ok` follows the 6-bit mask. Bit 0 applies to vsync lines, bit 1 to vback lines, bit 2 to vfront lines, bit 3 to the back porch of active lines, and bit 4 to the front porch of active lines. Bit 5 applies to the sync-active part of any line, and only in styles 1 to 3. `lp_ok` is never high in the active window.
- R10: Writes to timing, style or mask take effect at the next frame start, never mid-frame. The first frame's first cycle follows the second rising edge after the edge that stores run = 1.
- R11: Register map (word address, fields from bit 0):
  - 0 = control: bit 0 run, bit 1 command mode, bits 3:2 style, bits 9:4 low-power mask.
  - 1 = hsync cycles, 2 = hback cycles, 3 = line total cycles.
  - 4 = pixels per line (14 bits).
  - 5 = vsync lines, 6 = vback lines, 7 = vactive lines, 8 = vfront lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane-byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| sync_start | output | 1 | First cycle of a line |
| sync_end | output | 1 | End of sync-active, style 0 only |
| vsync_line | output | 1 | Current line is a vsync line |
| blank | output | 1 | Running and not in the active window |
| act | output | 1 | Active pixel window |
| eol | output | 1 | Last cycle of a line |
| eof | output | 1 | Last cycle of a frame |
| lp_ok | output | 1 | Lanes may return to low power |

## Verification
Some properties are checked on every cycle:
- the position counters never reach their span lengths;
- the front porch never goes negative;
- `eof` only coincides with `eol`, and every `eol` is followed by a line start;
- `lp_ok` never overlaps the active window;
- the frozen line and frame lengths do not move inside a frame;
- nothing is emitted while stopped or in command mode.

Only the bench's scenarios can show the exact cycle at which each strobe fires for each style, the burst shortening, the clamp of a short line total, the per-region meaning of each mask bit, and that a change written mid-frame appears exactly one frame later.

// File: rtl/dvt_pkg.sv
package dvt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  localparam logic [1:0] STYLE_PULSE = 2'd0;

  // register word addresses (R11)
  localparam int REG_CTRL   = 0;
  localparam int REG_HSYNC  = 1;  // 1..3: hsync, hback, line total
  localparam int REG_PIXELS = 4;
  localparam int REG_VSYNC  = 5;  // 5..8: vsync, vback, vactive, vfront

  // control word fields
  localparam int CTRL_RUN      = 0;
  localparam int CTRL_CMD      = 1;
  localparam int CTRL_STYLE_LO = 2;
  localparam int CTRL_LP_LO    = 4;
  localparam int LP_MASK_W     = 6;
  localparam int CTRL_W        = CTRL_LP_LO + LP_MASK_W;

  localparam int N_HREG = 3;
  localparam int N_VREG = 4;

endpackage

// File: rtl/dvt_regs.sv
module dvt_regs
  import dvt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int HW     = 16,
  parameter int VW     = 12,
  parameter int PIX_W  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 load,
  output logic                 run_req,
  output logic                 cmd_sel,
  output logic [1:0]           sh_style,
  output logic [LP_MASK_W-1:0] sh_lp,
  output logic [HW-1:0]        sh_hsa,
  output logic [HW-1:0]        sh_hbp,
  output logic [HW-1:0]        sh_hline,
  output logic [PIX_W-1:0]     sh_pix,
  output logic [VW-1:0]        sh_vsa,
  output logic [VW-1:0]        sh_vbp,
  output logic [VW-1:0]        sh_vact,
  output logic [VW-1:0]        sh_vfp
);

  logic [CTRL_W-1:0] lv_ctrl;
  logic [PIX_W-1:0]  lv_pix;
  logic [HW-1:0]     lv_h [N_HREG];
  logic [VW-1:0]     lv_v [N_VREG];

  logic [1:0]           sh_style_q;
  logic [LP_MASK_W-1:0] sh_lp_q;
  logic [PIX_W-1:0]     sh_pix_q;
  logic [HW-1:0]        sh_h [N_HREG];
  logic [VW-1:0]        sh_v [N_VREG];

  wire unused_wdata = ^wdata;

  // live bank: written by the configuration port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_ctrl <= '0;
      lv_pix  <= '0;
      for (int i = 0; i < N_HREG; i++) lv_h[i] <= '0;
      for (int i = 0; i < N_VREG; i++) lv_v[i] <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(REG_CTRL))   lv_ctrl <= wdata[CTRL_W-1:0];
      if (addr == ADDR_W'(REG_PIXELS)) lv_pix  <= wdata[PIX_W-1:0];
      for (int i = 0; i < N_HREG; i++)
        if (addr == ADDR_W'(REG_HSYNC + i)) lv_h[i] <= wdata[HW-1:0];
      for (int i = 0; i < N_VREG; i++)
        if (addr == ADDR_W'(REG_VSYNC + i)) lv_v[i] <= wdata[VW-1:0];
    end
  end

  // shadow bank: copied only at a frame boundary or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_style_q <= '0;
      sh_lp_q    <= '0;
      sh_pix_q   <= '0;
      for (int i = 0; i < N_HREG; i++) sh_h[i] <= '0;
      for (int i = 0; i < N_VREG; i++) sh_v[i] <= '0;
    end else if (load) begin
      sh_style_q <= lv_ctrl[CTRL_STYLE_LO +: 2];
      sh_lp_q    <= lv_ctrl[CTRL_LP_LO +: LP_MASK_W];
      sh_pix_q   <= lv_pix;
      for (int i = 0; i < N_HREG; i++) sh_h[i] <= lv_h[i];
      for (int i = 0; i < N_VREG; i++) sh_v[i] <= lv_v[i];
    end
  end

  assign run_req  = lv_ctrl[CTRL_RUN];
  assign cmd_sel  = lv_ctrl[CTRL_CMD];
  assign sh_style = sh_style_q;
  assign sh_lp    = sh_lp_q;
  assign sh_pix   = sh_pix_q;
  assign sh_hsa   = sh_h[0];
  assign sh_hbp   = sh_h[1];
  assign sh_hline = sh_h[2];
  assign sh_vsa   = sh_v[0];
  assign sh_vbp   = sh_v[1];
  assign sh_vact  = sh_v[2];
  assign sh_vfp   = sh_v[3];

endmodule

// File: rtl/dvt_span_cnt.sv
module dvt_span_cnt #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         last
);

  assign last = (cnt >= len - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= last ? '0 : cnt + W'(1);
  end

  // R3: the position never reaches the span length
  a_r3_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

endmodule

// File: rtl/dvt_region.sv
module dvt_region
  import dvt_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] end_sync,
  input  logic [W-1:0] end_back,
  input  logic [W-1:0] end_act,
  output seg_e         seg
);

  always_comb begin
    if (pos < end_sync)      seg = SEG_SYNC;
    else if (pos < end_back) seg = SEG_BACK;
    else if (pos < end_act)  seg = SEG_ACT;
    else                     seg = SEG_FRONT;
  end

endmodule

// File: rtl/dsi_video_timer.sv
module dsi_video_timer
  import dvt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int HW          = 16,
  parameter int VW          = 12,
  parameter int PIX_W       = 14,
  parameter int BURST_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              sync_start,
  output logic              sync_end,
  output logic              vsync_line,
  output logic              blank,
  output logic              act,
  output logic              eol,
  output logic              eof,
  output logic              lp_ok
);

  localparam int LW = HW + 2;  // line position width
  localparam int FW = VW + 2;  // frame line width

  // ---------------- arithmetic ----------------
  function automatic logic [LW-1:0] active_cycles(input logic [PIX_W-1:0] pix,
                                                  input logic burst);
    logic [LW-1:0] p;
    p = LW'(pix);
    if (!burst) return p;
    return (p + LW'((1 << BURST_SHIFT) - 1)) >> BURST_SHIFT;
  endfunction

  function automatic logic [LW-1:0] line_cycles(input logic [LW-1:0] used,
                                                input logic [HW-1:0] total);
    logic [LW-1:0] t;
    t = LW'(total);
    if (t < used) t = used;
    if (t == '0)  t = LW'(1);
    return t;
  endfunction

  function automatic logic [FW-1:0] frame_lines(input logic [FW-1:0] sum);
    return (sum == '0) ? FW'(1) : sum;
  endfunction

  // ---------------- configuration ----------------
  logic                 run_req, cmd_sel, load_cfg;
  logic [1:0]           sh_style;
  logic [LP_MASK_W-1:0] sh_lp;
  logic [HW-1:0]        sh_hsa, sh_hbp, sh_hline;
  logic [PIX_W-1:0]     sh_pix;
  logic [VW-1:0]        sh_vsa, sh_vbp, sh_vact, sh_vfp;

  dvt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW(HW), .VW(VW), .PIX_W(PIX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load_cfg), .run_req(run_req), .cmd_sel(cmd_sel),
    .sh_style(sh_style), .sh_lp(sh_lp),
    .sh_hsa(sh_hsa), .sh_hbp(sh_hbp), .sh_hline(sh_hline), .sh_pix(sh_pix),
    .sh_vsa(sh_vsa), .sh_vbp(sh_vbp), .sh_vact(sh_vact), .sh_vfp(sh_vfp)
  );

  // ---------------- start-up sequencer ----------------
  logic go, armed, running, video_on;
  assign go = run_req & ~cmd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      running <= 1'b0;
    end else begin
      armed   <= go;
      running <= go & armed;
    end
  end

  assign video_on = running & go;

  // ---------------- derived spans (named for assertions) ----------------
  logic pulse_style, burst_style;
  assign pulse_style = (sh_style == STYLE_PULSE);
  assign burst_style = sh_style[1];

  logic [LW-1:0] act_len, h_end_sync, h_end_back, h_end_act, line_len;
  logic [FW-1:0] v_end_sync, v_end_back, v_end_act, frame_len;

  assign act_len    = active_cycles(sh_pix, burst_style);
  assign h_end_sync = LW'(sh_hsa);
  assign h_end_back = h_end_sync + LW'(sh_hbp);
  assign h_end_act  = h_end_back + act_len;
  assign line_len   = line_cycles(h_end_act, sh_hline);

  assign v_end_sync = FW'(sh_vsa);
  assign v_end_back = v_end_sync + FW'(sh_vbp);
  assign v_end_act  = v_end_back + FW'(sh_vact);
  assign frame_len  = frame_lines(v_end_act + FW'(sh_vfp));

  // ---------------- position counters ----------------
  logic [LW-1:0] h_pos;
  logic [FW-1:0] v_pos;
  logic          h_last, v_last, frame_end;

  dvt_span_cnt #(.W(LW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(~video_on), .adv(1'b1),
    .len(line_len), .cnt(h_pos), .last(h_last)
  );

  dvt_span_cnt #(.W(FW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(~video_on), .adv(h_last),
    .len(frame_len), .cnt(v_pos), .last(v_last)
  );

  assign frame_end = video_on & h_last & v_last;
  assign load_cfg  = ~running | frame_end;

  seg_e h_seg, v_seg;

  dvt_region #(.W(LW)) u_hreg (
    .pos(h_pos), .end_sync(h_end_sync), .end_back(h_end_back),
    .end_act(h_end_act), .seg(h_seg)
  );

  dvt_region #(.W(FW)) u_vreg (
    .pos(v_pos), .end_sync(v_end_sync), .end_back(v_end_back),
    .end_act(v_end_act), .seg(v_seg)
  );

  // ---------------- strobes ----------------
  logic in_act, lp_sel;
  assign in_act = (v_seg == SEG_ACT) && (h_seg == SEG_ACT);

  always_comb begin
    lp_sel = 1'b0;
    if (h_seg == SEG_SYNC) begin
      lp_sel = ~pulse_style & sh_lp[5];
    end else if (!in_act) begin
      case (v_seg)
        SEG_SYNC:  lp_sel = sh_lp[0];
        SEG_BACK:  lp_sel = sh_lp[1];
        SEG_FRONT: lp_sel = sh_lp[2];
        default: begin
          if (h_seg == SEG_BACK)       lp_sel = sh_lp[3];
          else if (h_seg == SEG_FRONT) lp_sel = sh_lp[4];
        end
      endcase
    end
  end

  assign sync_start = video_on & (h_pos == '0);
  assign sync_end   = video_on & pulse_style & (h_pos == h_end_sync);
  assign vsync_line = video_on & (v_seg == SEG_SYNC);
  assign act        = video_on & in_act;
  assign blank      = video_on & ~in_act;
  assign eol        = video_on & h_last;
  assign eof        = frame_end;
  assign lp_ok      = video_on & lp_sel;

  // ---------------- assertions ----------------
  // R5: a frame ends only on a line end
  a_r5_eof_on_eol: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol);

  // R3: every line end is followed by a line start while running
  a_r3_eol_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> (sync_start || !video_on));

  // R4: the clamped front porch is never negative
  a_r4_porch_fits: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> (h_end_act <= line_len));

  // R9: low power is never allowed in the active window
  a_r9_lp_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !lp_ok);

  // R10: frozen spans do not move inside a frame
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end) |=> ($stable(line_len) && $stable(frame_len)));

  // R1, R2: nothing is emitted while stopped or in command mode
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !(sync_start | sync_end | vsync_line | blank | act | eol | eof | lp_ok));

endmodule

// File: tb/dsi_video_timer_bench.sv
module dsi_video_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic sync_start, sync_end, vsync_line, blank, act, eol, eof, lp_ok;

  always #5 clk = ~clk;

  dsi_video_timer u_dsi_video_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_start(sync_start), .sync_end(sync_end),
    .vsync_line(vsync_line), .blank(blank), .act(act), .eol(eol),
    .eof(eof), .lp_ok(lp_ok)
  );

  wire [7:0] obs = {sync_start, sync_end, vsync_line, blank, act, eol, eof, lp_ok};

  typedef struct {
    int hsa, hbp, hline, pix, vsa, vbp, vact, vfp, style;
    bit [5:0] lpm;
  } cfg_t;

  int checks = 0;
  int fails  = 0;
  bit mon_go = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic bit lp_of(int vr, int hr, bit act_b, cfg_t c);
    if (hr == 0) return (c.style != 0) && c.lpm[5];
    if (act_b) return 1'b0;
    if (vr == 0) return c.lpm[0];
    if (vr == 1) return c.lpm[1];
    if (vr == 3) return c.lpm[2];
    if (hr == 1) return c.lpm[3];
    if (hr == 3) return c.lpm[4];
    return 1'b0;
  endfunction

  function automatic logic [31:0] ctrl_word(cfg_t c, bit run, bit cmd);
    return {22'd0, c.lpm, 2'(c.style), cmd, run};
  endfunction

  // scoreboard driver: expected vector for each cycle of one frame
  task automatic push_frame(input cfg_t c, input string tag);
    int a, len, total, ln;
    int hl[4];
    int vc[4];
    a = (c.style >= 2) ? (c.pix + 1) / 2 : c.pix;
    len = c.hsa + c.hbp + a;
    if (c.hline > len) len = c.hline;
    if (len < 1) len = 1;
    hl[0] = c.hsa; hl[1] = c.hbp; hl[2] = a; hl[3] = len - (c.hsa + c.hbp + a);
    vc[0] = c.vsa; vc[1] = c.vbp; vc[2] = c.vact; vc[3] = c.vfp;
    total = c.vsa + c.vbp + c.vact + c.vfp;
    if (total == 0) begin vc[3] = 1; total = 1; end
    ln = 0;
    for (int vr = 0; vr < 4; vr++) begin
      for (int k = 0; k < vc[vr]; k++) begin
        int pos;
        pos = 0;
        for (int hr = 0; hr < 4; hr++) begin
          for (int j = 0; j < hl[hr]; j++) begin
            logic [7:0] v;
            bit act_b;
            act_b = (vr == 2) && (hr == 2);
            v[7] = (pos == 0);
            v[6] = (c.style == 0) && (pos == c.hsa);
            v[5] = (vr == 0);
            v[4] = !act_b;
            v[3] = act_b;
            v[2] = (pos == len - 1);
            v[1] = (pos == len - 1) && (ln == total - 1);
            v[0] = lp_of(vr, hr, act_b, c);
            exp_q.push_back(v);
            tag_q.push_back(tag);
            pos++;
          end
        end
        ln++;
      end
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_go && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (obs !== e) begin
          fails++;
          $display("FAIL %s: outputs actual=%b expected=%b", t, obs, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic write_cfg(input cfg_t c);
    wr(1, 32'(c.hsa)); wr(2, 32'(c.hbp)); wr(3, 32'(c.hline)); wr(4, 32'(c.pix));
    wr(5, 32'(c.vsa)); wr(6, 32'(c.vbp)); wr(7, 32'(c.vact)); wr(8, 32'(c.vfp));
  endtask

  task automatic start_run(input cfg_t c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = ctrl_word(c, 1'b1, 1'b0);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    @(posedge clk);
    @(posedge clk);
    mon_go = 1'b1;  // R10: first frame cycle follows the second edge
  endtask

  task automatic drain_and_stop(input cfg_t c);
    while (exp_q.size() != 0) @(negedge clk);
    mon_go = 1'b0;
    wr(0, ctrl_word(c, 1'b0, 1'b0));
  endtask

  task automatic check_idle(input int n, input string tag);
    int bad;
    logic [7:0] seen;
    bad = 0;
    seen = '0;
    repeat (n) begin
      @(negedge clk);
      if (obs !== 8'h00) begin bad++; seen = obs; end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, seen, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cfg_t ca, cb, cc, cd, ce, cf;
    ca = '{hsa:2, hbp:3, hline:20, pix:8, vsa:1, vbp:2, vact:3, vfp:1, style:0, lpm:6'b111111};
    cb = ca; cb.style = 1; cb.lpm = 6'b101010;
    cc = ca; cc.style = 2; cc.pix = 9; cc.lpm = 6'b010101;
    cd = cc; cd.style = 3; cd.hline = 10; cd.lpm = 6'b100011;
    ce = '{hsa:1, hbp:1, hline:4, pix:5, vsa:1, vbp:1, vact:2, vfp:1, style:0, lpm:6'b011000};
    cf = ca; cf.hline = 24; cf.vact = 2; cf.style = 1;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_idle(5, "R1 reset");

    write_cfg(ca);
    check_idle(10, "R1 run low");

    wr(0, ctrl_word(ca, 1'b1, 1'b1));
    check_idle(40, "R2 command mode");
    wr(0, ctrl_word(ca, 1'b0, 1'b0));

    // pulse style, two frames back to back
    push_frame(ca, "R3 R5 R6 R9 R11 pulse");
    push_frame(ca, "R3 R5 R6 R9 R11 pulse");
    start_run(ca);
    drain_and_stop(ca);
    check_idle(5, "R1 after stop");

    // sync events
    write_cfg(cb);
    push_frame(cb, "R7 R9 events");
    start_run(cb);
    drain_and_stop(cb);

    // burst, style 2 and the alternate code 3
    write_cfg(cc);
    push_frame(cc, "R8 R9 burst");
    start_run(cc);
    drain_and_stop(cc);
    write_cfg(cd);
    push_frame(cd, "R8 R9 burst alt");
    start_run(cd);
    drain_and_stop(cd);

    // line total shorter than its parts
    write_cfg(ce);
    push_frame(ce, "R4 clamp");
    push_frame(ce, "R4 clamp");
    start_run(ce);
    drain_and_stop(ce);

    // mid-frame update lands on the next frame
    write_cfg(ca);
    push_frame(ca, "R10 old frame");
    push_frame(cf, "R10 new frame");
    start_run(ca);
    repeat (30) @(negedge clk);
    wr(3, 32'(cf.hline));
    wr(7, 32'(cf.vact));
    wr(0, ctrl_word(cf, 1'b1, 1'b0));
    drain_and_stop(cf);
    check_idle(5, "R1 final stop");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule